// File: doc/BRIEF.md
# Multi-Processor Interrupt Mask Router

This block gathers device interrupt levels into one shared raw request word. Each of up to four processors has its own enable mask over that word. A processor's interrupt line is raised while any source that is both pending and enabled for it is active. The output of an external legacy cascaded controller is merged into one fixed bit of the raw word. That lets the legacy controller be enabled per processor like any other source.

Software uses a 64-bit register port to write the masks and read the masks, the per-processor masked views and the raw word. Offsets are byte offsets, and every access moves a full 64-bit word. A request is one cycle of `req_valid_i` carrying write flag, address and data. The block never applies back-pressure: `req_ready_o` is held high, so a request is accepted in the cycle it is presented. A response comes back in the following cycle and carries no handshake. The requester must take it in that cycle. Any offset outside the decoded set returns an error response with zero data.

Top module: `irq_mask_router`

## Requirements
- R1: The raw request register takes a copy of the source levels at each clock edge. A source held at 1 reads back as 1 in its bit, and a source held at 0 reads back as 0. The raw word is read at offset 0x300.
- R2: `irq_o[i]` is registered and equals the OR-reduction of mask i ANDed with the raw word. After a source level changes, it updates at the first clock edge, the same edge that loads the raw register.
- R3: Reading offset 0x280, 0x2C0, 0x680 or 0x6C0 returns mask 0, 1, 2 or 3 ANDed with the current raw word.
- R4: Writes to the four masked views and to the raw word change no state and return a response with no error.
- R5: `legacy_lvl_i` is ORed into raw bit 55 together with source 55.
- R6: Any offset other than the nine decoded ones returns `rsp_err_o`=1 and `rsp_rdata_o`=0. This includes offsets that are not 64-bit aligned. Writes to such offsets change no state.
- R7: A write to offset 0x200, 0x240, 0x600 or 0x640 replaces all 64 bits of mask 0, 1, 2 or 3. The new value reads back at that offset, and `irq_o` reflects the new mask from the edge that accepts the write.
- R8: Reset clears the masks, the raw word, the interrupt lines and the response outputs.
- R9: `req_ready_o` is always 1. Each accepted request yields exactly one response cycle (`rsp_valid_o`=1) on the next clock edge. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl_i | input | 64 | Device interrupt levels |
| legacy_lvl_i | input | 1 | Legacy controller output, merged into bit 55 |
| req_valid_i | input | 1 | Register request present |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset of the register |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response present, one cycle after the request |
| rsp_err_o | output | 1 | Offset not decoded |
| rsp_rdata_o | output | 64 | Read data; zero for writes and errors |
| irq_o | output | 4 | Hard interrupt line per processor |

## Verification
The assertions check on every cycle that each interrupt line matches its mask ANDed with the raw word, and that the raw word follows the previous cycle's source levels with the legacy merge. They also check that responses arrive exactly one cycle after requests, that error responses carry zero data, and that no mask changes unless a mask write was accepted. Only the bench scenarios can show that the address map is right. They do this by sweeping every 12-bit offset against an independent list. The scenarios also cover masks and views reading back the values a model predicts, writes to read-only views leaving the masks intact, and the single-bit sweep that proves each source reaches only the processors that enable it.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned CSR_ADDR_W = 12;
  localparam int unsigned CSR_DATA_W = 64;
  localparam int unsigned MAX_CPU    = 4;

  localparam logic [CSR_ADDR_W-1:0] VIEW_DELTA = 12'h080;
  localparam logic [CSR_ADDR_W-1:0] RAW_OFFSET = 12'h300;

  typedef enum logic [1:0] {
    CSR_NONE = 2'd0,
    CSR_MASK = 2'd1,
    CSR_VIEW = 2'd2,
    CSR_RAW  = 2'd3
  } csr_kind_e;

  typedef struct packed {
    csr_kind_e  kind;
    logic [1:0] cpu;
  } csr_sel_t;

  // Mask registers sit in two pairs: processors 0/1 low, 2/3 high.
  function automatic logic [CSR_ADDR_W-1:0] mask_offset(input int unsigned cpu);
    if (cpu < 2) return CSR_ADDR_W'(32'h200 + 32'h40 * cpu);
    return CSR_ADDR_W'(32'h600 + 32'h40 * (cpu - 2));
  endfunction

  function automatic csr_sel_t csr_decode(input logic [CSR_ADDR_W-1:0] addr,
                                          input int unsigned ncpu);
    csr_sel_t s;
    s.kind = CSR_NONE;
    s.cpu  = '0;
    if (addr == RAW_OFFSET) s.kind = CSR_RAW;
    for (int unsigned c = 0; c < MAX_CPU; c++) begin
      if (c < ncpu) begin
        if (addr == mask_offset(c)) begin
          s.kind = CSR_MASK;
          s.cpu  = 2'(c);
        end else if (addr == mask_offset(c) + VIEW_DELTA) begin
          s.kind = CSR_VIEW;
          s.cpu  = 2'(c);
        end
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
  parameter int unsigned NUM_SRC    = 64,
  parameter int unsigned LEGACY_BIT = 55
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               legacy_lvl,
  output logic [NUM_SRC-1:0] raw_d,
  output logic [NUM_SRC-1:0] raw_q
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_fold
    if (g == LEGACY_BIT) begin : g_merge
      assign raw_d[g] = src_lvl[g] | legacy_lvl;
    end else begin : g_pass
      assign raw_d[g] = src_lvl[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CPU-1:0]              wr_en,
  input  logic [NUM_SRC-1:0]              wr_val,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_d,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q
);

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    assign mask_d[g] = wr_en[g] ? wr_val : mask_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[g] <= '0;
      else        mask_q[g] <= mask_d[g];
    end
  end

endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_d,
  input  logic [NUM_SRC-1:0]              raw_d,
  output logic [NUM_CPU-1:0]              irq_q
);

  // Evaluated on next-state values so the line moves on the same edge
  // as the raw word and the mask it is derived from.
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[g] <= 1'b0;
      else        irq_q[g] <= |(mask_d[g] & raw_d);
    end
  end

endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [CSR_ADDR_W-1:0]           req_addr,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0]              raw_q,
  output logic [NUM_CPU-1:0]              mask_wr,
  output logic                            rsp_valid,
  output logic                            rsp_err,
  output logic [CSR_DATA_W-1:0]           rsp_rdata
);

  csr_sel_t              sel;
  logic [CSR_DATA_W-1:0] rd_mux;
  logic                  miss;

  always_comb sel = csr_decode(req_addr, NUM_CPU);
  assign miss = (sel.kind == CSR_NONE);

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_wr
    assign mask_wr[g] = req_valid && req_write && (sel.kind == CSR_MASK)
                        && (sel.cpu == 2'(g));
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel.kind)
      CSR_MASK: rd_mux = CSR_DATA_W'(mask_q[sel.cpu]);
      CSR_VIEW: rd_mux = CSR_DATA_W'(mask_q[sel.cpu] & raw_q);
      CSR_RAW:  rd_mux = CSR_DATA_W'(raw_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && miss;
      rsp_rdata <= (req_valid && !req_write && !miss) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU    = 4,
  parameter int unsigned NUM_SRC    = 64,
  parameter int unsigned LEGACY_BIT = 55
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    src_lvl_i,
  input  logic                  legacy_lvl_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_write_i,
  input  logic [CSR_ADDR_W-1:0] req_addr_i,
  input  logic [CSR_DATA_W-1:0] req_wdata_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_err_o,
  output logic [CSR_DATA_W-1:0] rsp_rdata_o,
  output logic [NUM_CPU-1:0]    irq_o
);

  logic [NUM_SRC-1:0]              raw_d;
  logic [NUM_SRC-1:0]              raw_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_d;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q;
  logic [NUM_CPU-1:0]              mask_wr;

  assign req_ready_o = 1'b1;

  irq_raw_capture #(.NUM_SRC(NUM_SRC), .LEGACY_BIT(LEGACY_BIT)) u_raw (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl_i), .legacy_lvl(legacy_lvl_i),
    .raw_d(raw_d), .raw_q(raw_q)
  );

  irq_mask_bank #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr),
    .wr_val(req_wdata_i[NUM_SRC-1:0]), .mask_d(mask_d), .mask_q(mask_q)
  );

  irq_line_drive #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_line (
    .clk(clk), .rst_n(rst_n), .mask_d(mask_d), .raw_d(raw_d), .irq_q(irq_o)
  );

  irq_csr_port #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_csr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid_i), .req_write(req_write_i),
    .req_addr(req_addr_i), .mask_q(mask_q), .raw_q(raw_q), .mask_wr(mask_wr),
    .rsp_valid(rsp_valid_o), .rsp_err(rsp_err_o), .rsp_rdata(rsp_rdata_o)
  );

endmodule

// File: rtl/irq_mask_router_checker.sv
module irq_mask_router_checker
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU    = 4,
  parameter int unsigned NUM_SRC    = 64,
  parameter int unsigned LEGACY_BIT = 55
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_SRC-1:0]              src_lvl_i,
  input logic                            legacy_lvl_i,
  input logic                            req_valid_i,
  input logic                            req_ready_o,
  input logic                            req_write_i,
  input logic [CSR_ADDR_W-1:0]           req_addr_i,
  input logic                            rsp_valid_o,
  input logic                            rsp_err_o,
  input logic [CSR_DATA_W-1:0]           rsp_rdata_o,
  input logic [NUM_CPU-1:0]              irq_o,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0]              raw_q
);

  logic               past_ok;
  logic [NUM_SRC-1:0] exp_raw;
  logic               mask_write_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    exp_raw = src_lvl_i;
    exp_raw[LEGACY_BIT] = exp_raw[LEGACY_BIT] | legacy_lvl_i;
  end

  assign mask_write_req = req_valid_i && req_write_i &&
                          (csr_decode(req_addr_i, NUM_CPU).kind == CSR_MASK);

  // R1 / R5
  assert_raw_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> raw_q == $past(exp_raw));

  // R2
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_irq
    assert_irq_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] == |(mask_q[g] & raw_q));
  end

  // R4 / R6
  assert_mask_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(mask_write_req)) |-> mask_q == $past(mask_q));

  // R6
  assert_err_no_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_err_o) |-> rsp_rdata_o == '0);

  // R9
  assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> rsp_valid_o == $past(req_valid_i));

  assert_ready_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o);

  // R8
  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> (irq_o == '0 && !rsp_valid_o));

endmodule

bind irq_mask_router irq_mask_router_checker #(
  .NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .LEGACY_BIT(LEGACY_BIT)
) u_checker (
  .clk(clk), .rst_n(rst_n), .src_lvl_i(src_lvl_i), .legacy_lvl_i(legacy_lvl_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
  .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o),
  .rsp_rdata_o(rsp_rdata_o), .irq_o(irq_o), .mask_q(mask_q), .raw_q(raw_q)
);

// File: tb/irq_mask_router_bench.sv
module irq_mask_router_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_lvl_i = '0;
  logic        legacy_lvl_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic        rsp_err_o;
  logic [63:0] rsp_rdata_o;
  logic [3:0]  irq_o;

  always #2.5 clk = ~clk;

  irq_mask_router u_irq_mask_router (.*);

  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  logic [63:0] m_mask [4];
  logic [63:0] m_src = '0;
  logic        m_leg = 1'b0;

  localparam logic [11:0] MOFF [4] = '{12'h200, 12'h240, 12'h600, 12'h640};
  localparam logic [11:0] VOFF [4] = '{12'h280, 12'h2C0, 12'h680, 12'h6C0};

  function automatic logic [63:0] exp_raw();
    logic [63:0] r = m_src;
    r[55] = r[55] | m_leg;
    return r;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) v[c] = |(m_mask[c] & exp_raw());
    return v;
  endfunction

  function automatic bit mapped(input logic [11:0] a);
    case (a)
      12'h200, 12'h240, 12'h600, 12'h640,
      12'h280, 12'h2C0, 12'h680, 12'h6C0, 12'h300: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [63:0] rd;
  logic        er;

  task automatic csr(input bit wr, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = d;
    if (wr) begin
      for (int c = 0; c < 4; c++) if (a == MOFF[c]) m_mask[c] = d;
    end
    @(posedge clk); #1;
    chk(rsp_valid_o === 1'b1, "R9 response valid", 64'(rsp_valid_o), 64'd1);
    rd = rsp_rdata_o; er = rsp_err_o;
    req_valid_i = 1'b0;
    @(posedge clk); #1;
    chk(rsp_valid_o === 1'b0, "R9 single response", 64'(rsp_valid_o), 64'd0);
  endtask

  task automatic set_src(input logic [63:0] s, input logic l, input string tag);
    @(negedge clk);
    src_lvl_i = s; legacy_lvl_i = l; m_src = s; m_leg = l;
    @(posedge clk); #1;
    chk(irq_o === exp_irq(), tag, 64'(irq_o), 64'(exp_irq()));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) m_mask[c] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(irq_o === 4'd0, "R8 irq at reset", 64'(irq_o), 64'd0);
    chk(rsp_valid_o === 1'b0, "R8 rsp at reset", 64'(rsp_valid_o), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R8: every register reads zero after reset
    for (int c = 0; c < 4; c++) begin
      csr(0, MOFF[c], '0); chk(rd === '0 && !er, "R8 mask zero", rd, '0);
      csr(0, VOFF[c], '0); chk(rd === '0 && !er, "R8 view zero", rd, '0);
    end
    csr(0, 12'h300, '0); chk(rd === '0, "R8 raw zero", rd, '0);

    // R7 / R3 / R1: full-width patterns
    set_src(64'hF0F0_3C3C_A5A5_0FF0, 1'b0, "R2 pattern source");
    for (int c = 0; c < 4; c++) begin
      logic [63:0] p = 64'h9E37_79B9_7F4A_7C15 * 64'(c + 1);
      csr(1, MOFF[c], p);
      chk(irq_o === exp_irq(), "R7 irq on mask write", 64'(irq_o), 64'(exp_irq()));
      chk(rd === '0 && !er, "R9 write data zero", rd, '0);
      csr(0, MOFF[c], '0); chk(rd === p, "R7 mask readback", rd, p);
      csr(0, VOFF[c], '0); chk(rd === (p & exp_raw()), "R3 view", rd, p & exp_raw());
    end
    csr(0, 12'h300, '0); chk(rd === exp_raw(), "R1 raw readback", rd, exp_raw());

    // R2 / R7: single-bit sweep, every processor and every source
    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b < 64; b++) begin
        csr(1, MOFF[c], 64'h1 << b);
        chk(irq_o === exp_irq(), "R7 single bit mask", 64'(irq_o), 64'(exp_irq()));
        set_src(64'h1 << b, 1'b0, "R2 bit asserted");
        set_src(~(64'h1 << b), 1'b0, "R2 bit deasserted");
      end
    end

    // R5: legacy merge into bit 55
    for (int c = 0; c < 4; c++) csr(1, MOFF[c], (c == 1) ? (64'h1 << 55) : 64'h0);
    set_src(64'h0, 1'b1, "R5 legacy raises irq");
    chk(irq_o === 4'b0010, "R5 legacy routed", 64'(irq_o), 64'b0010);
    csr(0, 12'h300, '0); chk(rd === (64'h1 << 55), "R5 legacy raw bit", rd, 64'h1 << 55);
    set_src(64'h1 << 55, 1'b0, "R5 source 55 alone");
    set_src(64'h0, 1'b0, "R5 both low");
    chk(irq_o === 4'b0000, "R5 cleared", 64'(irq_o), 64'd0);

    // R4: writes to read-only locations ignored
    set_src(64'hFFFF_0000_FFFF_0000, 1'b0, "R2 pre R4");
    for (int c = 0; c < 4; c++) begin
      csr(1, VOFF[c], '1); chk(!er, "R4 view write no error", 64'(er), 64'd0);
    end
    csr(1, 12'h300, '1); chk(!er, "R4 raw write no error", 64'(er), 64'd0);
    csr(0, 12'h300, '0); chk(rd === exp_raw(), "R4 raw unchanged", rd, exp_raw());
    for (int c = 0; c < 4; c++) begin
      csr(0, MOFF[c], '0); chk(rd === m_mask[c], "R4 mask unchanged", rd, m_mask[c]);
    end

    // R6: exhaustive decode sweep, plus unmapped writes
    for (int a = 0; a < 4096; a++) begin
      csr(0, 12'(a), '0);
      if (mapped(12'(a))) chk(!er, "R6 mapped no error", 64'(er), 64'd0);
      else chk(er && rd === '0, "R6 unmapped error", {er, rd[62:0]}, 64'h8000_0000_0000_0000);
    end
    csr(1, 12'h204, '1); chk(er, "R6 misaligned write error", 64'(er), 64'd1);
    csr(1, 12'h220, '1); chk(er, "R6 unmapped write error", 64'(er), 64'd1);
    for (int c = 0; c < 4; c++) begin
      csr(0, MOFF[c], '0); chk(rd === m_mask[c], "R6 masks untouched", rd, m_mask[c]);
    end
    chk(req_ready_o === 1'b1, "R9 ready high", 64'(req_ready_o), 64'd1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule